// File: doc/BRIEF.md
# UART Register and Interrupt Controller

This block is the software-facing side of a UART. A processor reaches it through a 32-bit register bus with byte offsets inside a 40-byte window. The block holds a transmit byte queue and a receive byte queue. It also holds the line-control, modem-control, baud-divisor and soft-reset registers, plus the sticky status flags. It drives one level-sensitive interrupt line. A write to the data offset queues a byte for transmission, and a read of the data offset takes the oldest received byte.

A serial engine sits on the far side. It sees the head of the transmit queue, pulses `tx_sent` when that byte's frame has gone out, and pulses `rx_strobe` with a byte when a frame arrives. It also reports parity, framing and break conditions as single-cycle pulses. Bit timing and line sampling live in that engine, not here.

Bus reads are registered. `bus_rdata` is valid on the cycle after the `bus_rd` strobe. Any side effect of the read, such as a queue pop or a flag clear, happens on that same clock edge.

Top module: `uart_regctl`

## Requirements
- R1: After reset, status reads 0x40, FIFO status (offset 0x10) reads 0x11, both count registers read 0, `tx_avail` is 0 and `irq` is 0.
- R2: Bytes written to offset 0x00 leave on `tx_data` in write order. Each `tx_sent` pulse removes the head byte. Offset 0x14 reads the transmit occupancy.
- R3: A data write while the transmit queue holds its full depth is discarded. That condition shows FIFO status bit 2 (TX full) and sets status bit 2 (overrun).
- R4: A byte written into an empty transmit queue clears status bits 5 (TX complete) and 6 (TX queue empty) and FIFO status bit 0. When `tx_sent` removes the last byte, all three are set.
- R5: A read of offset 0x00 returns the oldest stored receive byte and removes it. When the receive queue is empty, the read returns 0. Offset 0x18 reads the receive occupancy.
- R6: A byte arriving while the receive queue is full is dropped and sets FIFO status bit 6 (RX full). A successful data read clears that bit.
- R7: Every `rx_strobe` sets status bit 7 (RX data available), whether the byte was stored, dropped or refused.
- R8: A read of offset 0x04 returns the current status and then clears bits 7 and 5. A flag raised in the same cycle survives the read.
- R9: A data read that leaves the receive queue empty sets FIFO status bit 4 (RX empty) and clears status bit 2. A read that leaves bytes behind keeps bit 2.
- R10: A write to offset 0x08 sets reception on or off from data bit 5 (reset state: on). While reception is off, arriving bytes are not stored.
- R11: `irq` is high exactly while offset 0x08 bit 2 is set and at least one status bit among 0, 1, 2, 3, 5 and 7 is set.
- R12: Writing low byte 0x55 to offset 0x20 empties both queues and returns every register to its reset state. Any other value is stored, reads back from 0x20, and changes nothing else.
- R13: A nonzero write to offset 0x0C loads the divisor onto `baud_div`, and a zero write leaves it unchanged. A write to offset 0x04 drives `line_ctrl`, while reads of 0x04 return status.
- R14: Pulses on `rx_par_err`, `rx_frm_err` and `rx_brk` set status bits 0, 1 and 3, and status reads do not clear them. Undefined offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| tx_data | output | 8 | Head byte of the transmit queue |
| tx_avail | output | 1 | Transmit queue is not empty |
| tx_sent | input | 1 | Engine has finished the head byte's frame |
| rx_data | input | 8 | Received byte |
| rx_strobe | input | 1 | `rx_data` is a newly received byte |
| rx_par_err | input | 1 | Parity error pulse |
| rx_frm_err | input | 1 | Framing error pulse |
| rx_brk | input | 1 | Break condition pulse |
| line_ctrl | output | 8 | Line-control byte for the engine |
| baud_div | output | 16 | Baud divisor for the engine |
| rx_enable | output | 1 | Reception is on |
| irq | output | 1 | Level interrupt |

## Verification
The checker assumes the bus never strobes read and write in the same cycle, that offsets are word aligned, and that the engine's pulses last one cycle. The bench drives each bus access, engine pulse and receive byte in its own cycle, with an idle cycle between them, so no operation overlaps another. Queue-boundary properties are stated only for cycles with no soft-reset write, and the stimulus issues each soft reset as an isolated write.

// File: rtl/uart_regctl_pkg.sv
// Shared offsets, key value and bit positions for the UART register controller.
package uart_regctl_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_DATA  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_CS    = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_MODEM = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_DIV   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_FSTAT = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_TXCNT = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_RXCNT = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_SRST  = 6'h20;

    localparam logic [7:0] SRST_KEY = 8'h55;

    // status register bit positions
    localparam int ST_PAR = 0;
    localparam int ST_FRM = 1;
    localparam int ST_OVR = 2;
    localparam int ST_BRK = 3;
    localparam int ST_TXC = 5;
    localparam int ST_TXE = 6;
    localparam int ST_RXA = 7;

    // modem-control bit positions
    localparam int MC_IRQEN = 2;
    localparam int MC_RXEN  = 5;

    // status bits that can raise the interrupt
    localparam logic [7:0] IRQ_MASK = 8'hAF;
endpackage

// File: rtl/uart_byte_fifo.sv
// Byte queue with a combinational head and an occupancy count.
// Assumes DEPTH >= 2. A push while full and a pop while empty are ignored.
// flush empties the queue synchronously and takes priority over push and pop.
module uart_byte_fifo #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [7:0]       wdata,
    input  logic             pop,
    output logic [7:0]       head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);
    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // storage write, no reset needed
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/uart_stat_irq.sv
// Sticky status flags and the interrupt combiner.
// Event inputs are single-cycle. When an event sets a flag in the same cycle
// as a clearing condition, the set wins. tx_empty is a live queue state.
module uart_stat_irq
    import uart_regctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       stat_rd,
    input  logic       err_par,
    input  logic       err_frm,
    input  logic       err_brk,
    input  logic       tx_overflow,
    input  logic       tx_start,
    input  logic       tx_finish,
    input  logic       rx_arrive,
    input  logic       rx_drained,
    input  logic       tx_empty,
    input  logic       irq_en,
    output logic [7:0] stat,
    output logic       irq
);
    logic par_q, frm_q, ovr_q, brk_q, txc_q, rxa_q;

    // sticky flag update
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            par_q <= 1'b0;
            frm_q <= 1'b0;
            ovr_q <= 1'b0;
            brk_q <= 1'b0;
            txc_q <= 1'b0;
            rxa_q <= 1'b0;
        end else begin
            if (err_par) par_q <= 1'b1;
            if (err_frm) frm_q <= 1'b1;
            if (err_brk) brk_q <= 1'b1;
            if (tx_overflow)     ovr_q <= 1'b1;
            else if (rx_drained) ovr_q <= 1'b0;
            if (tx_finish)                 txc_q <= 1'b1;
            else if (tx_start || stat_rd)  txc_q <= 1'b0;
            if (rx_arrive)     rxa_q <= 1'b1;
            else if (stat_rd)  rxa_q <= 1'b0;
        end
    end

    // assemble status byte and gated interrupt level
    always_comb begin
        stat         = '0;
        stat[ST_PAR] = par_q;
        stat[ST_FRM] = frm_q;
        stat[ST_OVR] = ovr_q;
        stat[ST_BRK] = brk_q;
        stat[ST_TXC] = txc_q;
        stat[ST_TXE] = tx_empty;
        stat[ST_RXA] = rxa_q;
        irq          = irq_en && ((stat & IRQ_MASK) != '0);
    end
endmodule

// File: rtl/uart_regctl.sv
// UART register and interrupt controller: a bus register file plus TX/RX byte queues.
// Assumes bus_rd and bus_wr are never strobed together and that offsets are word aligned.
// Read data is registered, and read side effects happen on the strobe edge.
module uart_regctl
    import uart_regctl_pkg::*;
#(
    parameter int TX_DEPTH = 2048,
    parameter int RX_DEPTH = 1024,
    parameter int DIV_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [7:0]        tx_data,
    output logic              tx_avail,
    input  logic              tx_sent,
    input  logic [7:0]        rx_data,
    input  logic              rx_strobe,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    input  logic              rx_brk,
    output logic [7:0]        line_ctrl,
    output logic [DIV_W-1:0]  baud_div,
    output logic              rx_enable,
    output logic              irq
);
    localparam int TX_CW = $clog2(TX_DEPTH + 1);
    localparam int RX_CW = $clog2(RX_DEPTH + 1);

    logic [7:0]       ctrl_q, modem_q, srst_q;
    logic [DIV_W-1:0] div_q;
    logic             rx_on_q, rxf_q;
    logic [31:0]      rdata_q, rd_val;

    logic [7:0]       tx_head, rx_head;
    logic [TX_CW-1:0] tx_cnt;
    logic [RX_CW-1:0] rx_cnt;
    logic             tx_empty, tx_full, rx_empty, rx_full;
    logic [7:0]       stat_w, fstat;

    logic wr_data, wr_ctrl, wr_modem, wr_div, wr_srst, srst;
    logic rd_data, rd_stat;
    logic tx_overflow, tx_start, tx_pop_ok, tx_finish;
    logic rx_store, rx_store_ok, rx_drop, rx_pop_ok, rx_drained;

    // address decode of the bus strobes
    always_comb begin
        wr_data  = bus_wr && (bus_addr == OFS_DATA);
        wr_ctrl  = bus_wr && (bus_addr == OFS_CS);
        wr_modem = bus_wr && (bus_addr == OFS_MODEM);
        wr_div   = bus_wr && (bus_addr == OFS_DIV);
        wr_srst  = bus_wr && (bus_addr == OFS_SRST);
        srst     = wr_srst && (bus_wdata[7:0] == SRST_KEY);
        rd_data  = bus_rd && (bus_addr == OFS_DATA);
        rd_stat  = bus_rd && (bus_addr == OFS_CS);
    end

    // queue events feeding the status flags
    always_comb begin
        tx_overflow = wr_data && tx_full;
        tx_start    = wr_data && tx_empty;
        tx_pop_ok   = tx_sent && !tx_empty;
        tx_finish   = tx_pop_ok && (tx_cnt == TX_CW'(1)) && !wr_data;
        rx_store    = rx_strobe && rx_on_q;
        rx_store_ok = rx_store && !rx_full;
        rx_drop     = rx_store && rx_full;
        rx_pop_ok   = rd_data && !rx_empty;
        rx_drained  = rd_data && !rx_store_ok && (rx_cnt <= RX_CW'(1));
    end

    uart_byte_fifo #(.DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(srst),
        .push(wr_data), .wdata(bus_wdata[7:0]), .pop(tx_sent),
        .head(tx_head), .count(tx_cnt), .empty(tx_empty), .full(tx_full)
    );

    uart_byte_fifo #(.DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(srst),
        .push(rx_store), .wdata(rx_data), .pop(rd_data),
        .head(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full)
    );

    uart_stat_irq u_stat (
        .clk(clk), .rst_n(rst_n), .flush(srst), .stat_rd(rd_stat),
        .err_par(rx_par_err), .err_frm(rx_frm_err), .err_brk(rx_brk),
        .tx_overflow(tx_overflow), .tx_start(tx_start), .tx_finish(tx_finish),
        .rx_arrive(rx_strobe), .rx_drained(rx_drained), .tx_empty(tx_empty),
        .irq_en(modem_q[MC_IRQEN]), .stat(stat_w), .irq(irq)
    );

    // control registers, soft reset shares the reset path
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            ctrl_q  <= '0;
            modem_q <= '0;
            div_q   <= '0;
            srst_q  <= '0;
            rx_on_q <= 1'b1;
            rxf_q   <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata[7:0];
            if (wr_modem) begin
                modem_q <= bus_wdata[7:0];
                rx_on_q <= bus_wdata[MC_RXEN];
            end
            if (wr_div && (bus_wdata != 32'd0)) div_q <= bus_wdata[DIV_W-1:0];
            if (wr_srst) srst_q <= bus_wdata[7:0];
            if (rx_drop)        rxf_q <= 1'b1;
            else if (rx_pop_ok) rxf_q <= 1'b0;
        end
    end

    // FIFO status byte: TX empty, TX full, RX empty, RX full on even bits
    always_comb begin
        fstat    = '0;
        fstat[0] = tx_empty;
        fstat[2] = tx_full;
        fstat[4] = rx_empty;
        fstat[6] = rxf_q;
    end

    // read data selection
    always_comb begin
        case (bus_addr)
            OFS_DATA:  rd_val = rx_empty ? 32'd0 : {24'd0, rx_head};
            OFS_CS:    rd_val = {24'd0, stat_w};
            OFS_MODEM: rd_val = {24'd0, modem_q};
            OFS_DIV:   rd_val = 32'(div_q);
            OFS_FSTAT: rd_val = {24'd0, fstat};
            OFS_TXCNT: rd_val = 32'(tx_cnt);
            OFS_RXCNT: rd_val = 32'(rx_cnt);
            OFS_SRST:  rd_val = {24'd0, srst_q};
            default:   rd_val = 32'd0;
        endcase
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_val;
    end

    assign bus_rdata = rdata_q;
    assign tx_data   = tx_head;
    assign tx_avail  = !tx_empty;
    assign line_ctrl = ctrl_q;
    assign baud_div  = div_q;
    assign rx_enable = rx_on_q;
endmodule

// File: rtl/uart_regctl_chk.sv
// Property checker for uart_regctl, attached with bind. It observes ports and queue/status state.
module uart_regctl_chk
    import uart_regctl_pkg::*;
#(
    parameter int TX_DEPTH = 2048,
    parameter int RX_DEPTH = 1024,
    parameter int DIV_W    = 16,
    localparam int TX_CW = $clog2(TX_DEPTH + 1),
    localparam int RX_CW = $clog2(RX_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [5:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [31:0]      bus_wdata,
    input logic             tx_sent,
    input logic             rx_strobe,
    input logic [DIV_W-1:0] baud_div,
    input logic             irq,
    input logic [TX_CW-1:0] tx_cnt,
    input logic [RX_CW-1:0] rx_cnt,
    input logic [7:0]       stat
);
    // input rule: read and write strobes never overlap
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    // R3
    tx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt == TX_CW'(TX_DEPTH) && bus_wr && bus_addr == OFS_DATA && !tx_sent)
        |=> (tx_cnt == TX_CW'(TX_DEPTH)));

    // R4
    tx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sent && tx_cnt == TX_CW'(1) &&
         !(bus_wr && (bus_addr == OFS_DATA || bus_addr == OFS_SRST)))
        |=> (stat[ST_TXC] && stat[ST_TXE]));

    // R7
    rx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && !(bus_wr && bus_addr == OFS_SRST)) |=> stat[ST_RXA]);

    // R8
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_CS && !rx_strobe && !(tx_sent && tx_cnt == TX_CW'(1)))
        |=> (!stat[ST_RXA] && !stat[ST_TXC]));

    // R12
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_SRST && bus_wdata[7:0] == SRST_KEY)
        |=> (tx_cnt == '0 && rx_cnt == '0 && !irq));

    // R13
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DIV && bus_wdata == 32'd0) |=> $stable(baud_div));
endmodule

bind uart_regctl uart_regctl_chk #(
    .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .DIV_W(DIV_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .tx_sent(tx_sent), .rx_strobe(rx_strobe),
    .baud_div(baud_div), .irq(irq), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .stat(stat_w)
);

// File: tb/sim_uart_regctl.sv
// Bench for uart_regctl with small queues: sweeps of queue fill levels, interrupt causes and reset keys.
module sim_uart_regctl;
    import uart_regctl_pkg::*;

    localparam int TXD = 4;
    localparam int RXD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_data, rx_data = '0, line_ctrl;
    logic        tx_avail, tx_sent = 1'b0, rx_strobe = 1'b0;
    logic        rx_par_err = 1'b0, rx_frm_err = 1'b0, rx_brk = 1'b0;
    logic [15:0] baud_div;
    logic        rx_enable, irq;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    uart_regctl #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .DIV_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data), .tx_avail(tx_avail),
        .tx_sent(tx_sent), .rx_data(rx_data), .rx_strobe(rx_strobe), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_brk(rx_brk), .line_ctrl(line_ctrl), .baud_div(baud_div),
        .rx_enable(rx_enable), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic send_rx(input logic [7:0] b);
        @(negedge clk);
        rx_data = b; rx_strobe = 1'b1;
        @(negedge clk);
        rx_strobe = 1'b0;
    endtask

    task automatic frame_done();
        @(negedge clk);
        tx_sent = 1'b1;
        @(negedge clk);
        tx_sent = 1'b0;
    endtask

    // 0 parity, 1 framing, 2 break
    task automatic err_pulse(input int which);
        @(negedge clk);
        rx_par_err = (which == 0);
        rx_frm_err = (which == 1);
        rx_brk     = (which == 2);
        @(negedge clk);
        rx_par_err = 1'b0; rx_frm_err = 1'b0; rx_brk = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(OFS_CS, v);    chk("R1 status", v, 32'h40);
        bus_read(OFS_FSTAT, v); chk("R1 fifo status", v, 32'h11);
        bus_read(OFS_TXCNT, v); chk("R1 tx count", v, 0);
        bus_read(OFS_RXCNT, v); chk("R1 rx count", v, 0);
        chk("R1 tx_avail", 32'(tx_avail), 0);
        chk("R1 irq", 32'(irq), 0);

        // R2 R3 R4 transmit fill sweep
        for (int n = 1; n <= TXD + 2; n++) begin
            int kept;
            kept = (n < TXD) ? n : TXD;
            for (int i = 0; i < n; i++) bus_write(OFS_DATA, 32'hA0 + i);
            bus_read(OFS_TXCNT, v); chk("R2 tx count", v, kept);
            bus_read(OFS_FSTAT, v);
            chk("R3 tx full bit", 32'(v[2]), (n >= TXD) ? 1 : 0);
            chk("R4 fifo tx empty cleared", 32'(v[0]), 0);
            bus_read(OFS_CS, v); chk("R3 R4 status after fill", v, (n > TXD) ? 32'h04 : 32'h00);
            for (int j = 0; j < kept; j++) begin
                chk("R2 tx head order", 32'(tx_data), 32'hA0 + j);
                frame_done();
            end
            chk("R4 tx_avail drained", 32'(tx_avail), 0);
            bus_read(OFS_CS, v); chk("R4 done flags", v, 32'h60 | ((n > TXD) ? 32'h04 : 32'h00));
            bus_read(OFS_DATA, v); chk("R5 empty read", v, 0);
            bus_read(OFS_CS, v); chk("R8 R9 cleared", v, 32'h40);
        end

        // R5 R6 R7 R9 receive fill sweep
        for (int n = 0; n <= RXD + 2; n++) begin
            int kept;
            kept = (n < RXD) ? n : RXD;
            for (int i = 0; i < n; i++) send_rx(8'h30 + 8'(i));
            bus_read(OFS_RXCNT, v); chk("R5 rx count", v, kept);
            bus_read(OFS_FSTAT, v);
            chk("R6 R9 fifo status", v, 32'h01 | ((n == 0) ? 32'h10 : 0) | ((n > RXD) ? 32'h40 : 0));
            bus_read(OFS_CS, v); chk("R7 rx avail", v, 32'h40 | ((n > 0) ? 32'h80 : 0));
            for (int j = 0; j < kept; j++) begin
                bus_read(OFS_DATA, v); chk("R5 rx order", v, 32'h30 + j);
            end
            bus_read(OFS_DATA, v); chk("R5 read past end", v, 0);
            bus_read(OFS_FSTAT, v); chk("R6 R9 fifo status after drain", v, 32'h11);
        end

        // R9 overrun kept while bytes remain
        for (int i = 0; i < TXD + 1; i++) bus_write(OFS_DATA, 32'h11);
        send_rx(8'h01); send_rx(8'h02);
        bus_read(OFS_DATA, v);
        bus_read(OFS_CS, v); chk("R9 overrun kept", 32'(v[2]), 1);
        bus_read(OFS_DATA, v);
        bus_read(OFS_CS, v); chk("R9 overrun cleared", 32'(v[2]), 0);
        bus_write(OFS_SRST, 32'h55);

        // R10 reception enable
        bus_write(OFS_MODEM, 32'h00);
        chk("R10 rx_enable off", 32'(rx_enable), 0);
        send_rx(8'h77);
        bus_read(OFS_RXCNT, v); chk("R10 not stored", v, 0);
        bus_read(OFS_CS, v); chk("R7 flag while off", 32'(v[7]), 1);
        bus_write(OFS_MODEM, 32'h20);
        send_rx(8'h78);
        bus_read(OFS_RXCNT, v); chk("R10 stored", v, 1);
        bus_read(OFS_DATA, v); chk("R10 byte", v, 32'h78);

        // R11 interrupt cause x enable sweep
        for (int en = 0; en < 2; en++) begin
            for (int k = 0; k < 6; k++) begin
                bus_write(OFS_SRST, 32'h55);
                bus_write(OFS_MODEM, (en != 0) ? 32'h24 : 32'h20);
                chk("R11 idle low", 32'(irq), 0);
                case (k)
                    0, 1, 2: err_pulse(k);
                    3: for (int i = 0; i < TXD + 1; i++) bus_write(OFS_DATA, 32'h5A);
                    4: begin bus_write(OFS_DATA, 32'h5B); frame_done(); end
                    default: send_rx(8'h42);
                endcase
                chk("R11 cause level", 32'(irq), 32'(en));
                if (k >= 4) begin
                    bus_read(OFS_CS, v);
                    chk("R8 read clears cause", 32'(irq), 0);
                end
            end
        end

        // R12 soft reset key
        bus_write(OFS_SRST, 32'h55);
        bus_write(OFS_MODEM, 32'h24);
        send_rx(8'h99);
        for (int t = 0; t < 4; t++) begin
            logic [7:0] key;
            key = (t == 0) ? 8'h54 : (t == 1) ? 8'h56 : (t == 2) ? 8'hAA : 8'h00;
            bus_write(OFS_SRST, {24'd0, key});
            bus_read(OFS_SRST, v); chk("R12 stored value", v, {24'd0, key});
            bus_read(OFS_RXCNT, v); chk("R12 no effect", v, 1);
            chk("R12 irq kept", 32'(irq), 1);
        end
        bus_write(OFS_SRST, 32'h55);
        bus_read(OFS_SRST, v);  chk("R12 reset reg", v, 0);
        bus_read(OFS_RXCNT, v); chk("R12 rx flushed", v, 0);
        bus_read(OFS_MODEM, v); chk("R12 modem cleared", v, 0);
        bus_read(OFS_CS, v);    chk("R12 status", v, 32'h40);
        chk("R12 irq", 32'(irq), 0);

        // R13 divisor and line control
        bus_write(OFS_DIV, 32'h1A2B);
        bus_read(OFS_DIV, v); chk("R13 divisor read", v, 32'h1A2B);
        bus_write(OFS_DIV, 32'h0);
        chk("R13 zero ignored", 32'(baud_div), 32'h1A2B);
        bus_write(OFS_CS, 32'h0E);
        chk("R13 line_ctrl", 32'(line_ctrl), 32'h0E);
        bus_read(OFS_CS, v); chk("R13 read gives status", v, 32'h40);

        // R14 line errors and undefined offsets
        for (int e = 0; e < 3; e++) begin
            bus_write(OFS_SRST, 32'h55);
            err_pulse(e);
            bus_read(OFS_CS, v);
            chk("R14 error bit", v, 32'h40 | ((e == 0) ? 32'h1 : (e == 1) ? 32'h2 : 32'h8));
            bus_read(OFS_CS, v);
            chk("R14 not cleared", v, 32'h40 | ((e == 0) ? 32'h1 : (e == 1) ? 32'h2 : 32'h8));
        end
        bus_write(6'h1C, 32'hFFFF_FFFF);
        bus_write(6'h24, 32'hFFFF_FFFF);
        bus_read(6'h1C, v); chk("R14 undefined 1C", v, 0);
        bus_read(6'h24, v); chk("R14 undefined 24", v, 0);
        bus_read(OFS_TXCNT, v); chk("R14 write ignored", v, 0);

        report();
        $finish;
    end
endmodule